// File: doc/BRIEF.md
# ISDN Slot Steering for Parallel HDLC Channels

This block sits between a serial-line TDM framer and three bit-serial HDLC controllers. It gives ISDN basic-rate (2B+D) service on the leading time slots of every frame. The framer tells it when a serial bit time occurs (`bit_stb`) and which time slot that bit belongs to (`slot_idx`). When ISDN mode is on, each of the first `NUM_CH` slots is tied to its own HDLC channel. Slot k goes to channel bit k. That channel receives a one-cycle enable for each bit of its slot, together with the line bit captured at that moment.

In the transmit direction, the line bit for slots 0 to `NUM_CH-1` comes from the matching HDLC channel. If that channel has no bit ready, the line carries a 1. All other slots, and every slot while ISDN mode is off, carry the bit supplied by the normal transmit frame buffer. The receive tap toward the normal frame buffers sees every bit of every slot whatever the mode, so the buffers keep working in parallel with the HDLC channels.

A small address decoder splits processor register addresses into windows. An upper nibble of k+1 (1 to `NUM_CH`) selects HDLC channel bit k, with the lower bits passed on as the register offset inside that channel. Channel bit 1 therefore owns 0x20 to 0x2F. Every other upper nibble selects the base TDM register set.

Top module: `isdn_slot_steer`

## Requirements
- R1: During and right after the asynchronous active-low reset, `ch_en` and `ch_rx_bit` are all zero, `buf_rx_stb` and `buf_rx_bit` are 0, `line_tx` is 1, `ch_sel` is zero, `base_sel` is 1 and `reg_ofs` is 0.
- R2: One cycle after a clock edge that samples `bit_stb`=1, `isdn_en`=1 and `slot_idx`=k with k < `NUM_CH`, `ch_en[k]` is 1 for exactly that one cycle. No other bit of `ch_en` is ever 1 in that cycle. `ch_en` is zero after any edge that samples `bit_stb`=0.
- R3: While `isdn_en` is sampled 0, `ch_en` stays zero and `line_tx` takes `buf_tx_bit` on every bit strobe, for every slot.
- R4: `ch_rx_bit[k]` loads the `line_rx` value sampled at the same edge that raises `ch_en[k]`, and holds its value at every other edge.
- R5: On every edge, `buf_rx_stb` takes the sampled `bit_stb`. When `bit_stb` is 1, `buf_rx_bit` takes `line_rx`; otherwise it holds. Neither the mode nor the slot number affects this.
- R6: With `isdn_en`=1 and slot k < `NUM_CH` on a bit strobe, `line_tx` takes `hdlc_tx_bit[k]` when `hdlc_tx_vld[k]` is 1.
- R7: In the same situation with `hdlc_tx_vld[k]`=0, `line_tx` becomes 1, whatever `hdlc_tx_bit[k]` and `buf_tx_bit` are.
- R8: For slots k >= `NUM_CH`, `line_tx` takes `buf_tx_bit` on a bit strobe in either mode. HDLC inputs have no effect.
- R9: `line_tx` keeps its value after an edge that samples `bit_stb`=0.
- R10: One cycle after `cpu_addr` is sampled with upper nibble n in 1..`NUM_CH`, `ch_sel` is one-hot with bit n-1 set, `base_sel` is 0, and `reg_ofs` equals the lower `ADDR_W-4` address bits.
- R11: One cycle after `cpu_addr` is sampled with upper nibble 0 or greater than `NUM_CH`, `ch_sel` is zero, `base_sel` is 1, and `reg_ofs` equals the lower `ADDR_W-4` address bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit-rate clock domain clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| isdn_en | input | 1 | ISDN steering mode enable (control register bit) |
| bit_stb | input | 1 | One-cycle pulse per serial bit time from the framer |
| slot_idx | input | SLOT_W | Time slot of the current bit |
| line_rx | input | 1 | Received line bit |
| buf_tx_bit | input | 1 | Transmit bit from the normal frame buffer path |
| hdlc_tx_bit | input | NUM_CH | Transmit bit offered by each HDLC channel |
| hdlc_tx_vld | input | NUM_CH | Per-channel flag that the offered bit is valid |
| cpu_addr | input | ADDR_W | Processor register address |
| ch_en | output | NUM_CH | Per-channel bit enable, active in the channel's own slot |
| ch_rx_bit | output | NUM_CH | Per-channel captured receive bit |
| buf_rx_stb | output | 1 | Bit strobe toward the normal receive buffer |
| buf_rx_bit | output | 1 | Receive bit toward the normal receive buffer |
| line_tx | output | 1 | Transmit line bit |
| ch_sel | output | NUM_CH | One-hot HDLC register window select |
| base_sel | output | 1 | Base TDM register set select |
| reg_ofs | output | ADDR_W-4 | Register offset inside the selected window |

## Verification
The bench builds the block with its defaults: `NUM_CH`=3, `SLOT_W`=5 and `ADDR_W`=8. With these values all 32 slots of a frame can be driven, including slot 3, the first slot past the steered range. Every one of the 16 upper address nibbles can be applied, so nibble 0 and nibble 4, which lie on both sides of the channel windows, are exercised next to the three window values. Random slot, strobe, mode and valid patterns are mixed with full-frame sweeps in both modes.

// File: rtl/isdn_steer_pkg.sv
package isdn_steer_pkg;
    localparam int NIB_W = 4;

    typedef struct packed {
        logic en;
        logic rx;
    } gate_st_t;

    typedef struct packed {
        logic line;
        logic rx_stb;
        logic rx_bit;
    } txsel_st_t;
endpackage

// File: rtl/isdn_chan_gate.sv
module isdn_chan_gate
    import isdn_steer_pkg::*;
#(
    parameter int SLOT_W  = 5,
    parameter int CH_SLOT = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              isdn_en,
    input  logic              bit_stb,
    input  logic [SLOT_W-1:0] slot_idx,
    input  logic              line_rx,
    output logic              en_o,
    output logic              rx_o
);
    localparam logic [SLOT_W-1:0] MY_SLOT = SLOT_W'(CH_SLOT);

    gate_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.en = bit_stb && isdn_en && (slot_idx == MY_SLOT);
        if (st_d.en) begin
            st_d.rx = line_rx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o = st_q.en;
    assign rx_o = st_q.rx;
endmodule

// File: rtl/isdn_tx_select.sv
module isdn_tx_select
    import isdn_steer_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int SLOT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              isdn_en,
    input  logic              bit_stb,
    input  logic [SLOT_W-1:0] slot_idx,
    input  logic              line_rx,
    input  logic              buf_tx_bit,
    input  logic [NUM_CH-1:0] hdlc_tx_bit,
    input  logic [NUM_CH-1:0] hdlc_tx_vld,
    output logic              line_tx_o,
    output logic              rx_stb_o,
    output logic              rx_bit_o
);
    txsel_st_t st_d, st_q;
    logic      steered;
    logic      chan_bit;

    always_comb begin
        steered  = 1'b0;
        chan_bit = 1'b1;
        for (int k = 0; k < NUM_CH; k++) begin
            if (slot_idx == SLOT_W'(k)) begin
                steered  = isdn_en;
                chan_bit = hdlc_tx_vld[k] ? hdlc_tx_bit[k] : 1'b1;
            end
        end

        st_d        = st_q;
        st_d.rx_stb = bit_stb;
        if (bit_stb) begin
            st_d.rx_bit = line_rx;
            st_d.line   = steered ? chan_bit : buf_tx_bit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{line: 1'b1, rx_stb: 1'b0, rx_bit: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign line_tx_o = st_q.line;
    assign rx_stb_o  = st_q.rx_stb;
    assign rx_bit_o  = st_q.rx_bit;
endmodule

// File: rtl/isdn_win_decode.sv
module isdn_win_decode
    import isdn_steer_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int ADDR_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       cpu_addr,
    output logic [NUM_CH-1:0]       ch_sel_o,
    output logic                    base_sel_o,
    output logic [ADDR_W-NIB_W-1:0] reg_ofs_o
);
    localparam int OFS_W = ADDR_W - NIB_W;

    typedef struct packed {
        logic [NUM_CH-1:0] sel;
        logic              base;
        logic [OFS_W-1:0]  ofs;
    } dec_st_t;

    dec_st_t          st_d, st_q;
    logic [NIB_W-1:0] win;

    always_comb begin
        win      = cpu_addr[ADDR_W-1 -: NIB_W];
        st_d     = st_q;
        st_d.ofs = cpu_addr[OFS_W-1:0];
        st_d.sel = '0;
        for (int k = 0; k < NUM_CH; k++) begin
            if (win == NIB_W'(k + 1)) begin
                st_d.sel[k] = 1'b1;
            end
        end
        st_d.base = (st_d.sel == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{sel: '0, base: 1'b1, ofs: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign ch_sel_o   = st_q.sel;
    assign base_sel_o = st_q.base;
    assign reg_ofs_o  = st_q.ofs;
endmodule

// File: rtl/isdn_slot_steer.sv
module isdn_slot_steer
    import isdn_steer_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int SLOT_W = 5,
    parameter int ADDR_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    isdn_en,
    input  logic                    bit_stb,
    input  logic [SLOT_W-1:0]       slot_idx,
    input  logic                    line_rx,
    input  logic                    buf_tx_bit,
    input  logic [NUM_CH-1:0]       hdlc_tx_bit,
    input  logic [NUM_CH-1:0]       hdlc_tx_vld,
    input  logic [ADDR_W-1:0]       cpu_addr,
    output logic [NUM_CH-1:0]       ch_en,
    output logic [NUM_CH-1:0]       ch_rx_bit,
    output logic                    buf_rx_stb,
    output logic                    buf_rx_bit,
    output logic                    line_tx,
    output logic [NUM_CH-1:0]       ch_sel,
    output logic                    base_sel,
    output logic [ADDR_W-NIB_W-1:0] reg_ofs
);
    // One gate per steered slot; slot k feeds channel bit k.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        isdn_chan_gate #(
            .SLOT_W (SLOT_W),
            .CH_SLOT(g)
        ) u_gate (
            .clk     (clk),
            .rst_n   (rst_n),
            .isdn_en (isdn_en),
            .bit_stb (bit_stb),
            .slot_idx(slot_idx),
            .line_rx (line_rx),
            .en_o    (ch_en[g]),
            .rx_o    (ch_rx_bit[g])
        );
    end

    isdn_tx_select #(
        .NUM_CH(NUM_CH),
        .SLOT_W(SLOT_W)
    ) u_txsel (
        .clk        (clk),
        .rst_n      (rst_n),
        .isdn_en    (isdn_en),
        .bit_stb    (bit_stb),
        .slot_idx   (slot_idx),
        .line_rx    (line_rx),
        .buf_tx_bit (buf_tx_bit),
        .hdlc_tx_bit(hdlc_tx_bit),
        .hdlc_tx_vld(hdlc_tx_vld),
        .line_tx_o  (line_tx),
        .rx_stb_o   (buf_rx_stb),
        .rx_bit_o   (buf_rx_bit)
    );

    isdn_win_decode #(
        .NUM_CH(NUM_CH),
        .ADDR_W(ADDR_W)
    ) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_addr  (cpu_addr),
        .ch_sel_o  (ch_sel),
        .base_sel_o(base_sel),
        .reg_ofs_o (reg_ofs)
    );
endmodule

// File: rtl/isdn_slot_steer_chk.sv
module isdn_slot_steer_chk #(
    parameter int NUM_CH = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              isdn_en,
    input logic              bit_stb,
    input logic [NUM_CH-1:0] ch_en,
    input logic [NUM_CH-1:0] ch_rx_bit,
    input logic              buf_rx_stb,
    input logic              line_tx,
    input logic [NUM_CH-1:0] ch_sel,
    input logic              base_sel
);
    // R2
    ch_en_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_en));

    // R2
    ch_en_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_en != '0) |-> $past(bit_stb));

    // R3
    ch_en_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(isdn_en) |-> (ch_en == '0));

    // R4
    ch_rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_en == '0) |-> $stable(ch_rx_bit));

    // R5
    rx_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bit_stb) |-> buf_rx_stb);

    // R9
    line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bit_stb) |-> $stable(line_tx));

    // R10
    win_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_sel));

    // R11
    win_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|ch_sel) |-> !base_sel);
endmodule

bind isdn_slot_steer isdn_slot_steer_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .isdn_en   (isdn_en),
    .bit_stb   (bit_stb),
    .ch_en     (ch_en),
    .ch_rx_bit (ch_rx_bit),
    .buf_rx_stb(buf_rx_stb),
    .line_tx   (line_tx),
    .ch_sel    (ch_sel),
    .base_sel  (base_sel)
);

// File: tb/isdn_slot_steer_test.sv
`timescale 1ns/1ps
module isdn_slot_steer_test;
    localparam int NUM_CH = 3;
    localparam int SLOT_W = 5;
    localparam int ADDR_W = 8;
    localparam int OFS_W  = ADDR_W - 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              isdn_en = 1'b0;
    logic              bit_stb = 1'b0;
    logic [SLOT_W-1:0] slot_idx = '0;
    logic              line_rx = 1'b0;
    logic              buf_tx_bit = 1'b0;
    logic [NUM_CH-1:0] hdlc_tx_bit = '0;
    logic [NUM_CH-1:0] hdlc_tx_vld = '0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic [NUM_CH-1:0] ch_en, ch_rx_bit, ch_sel;
    logic              buf_rx_stb, buf_rx_bit, line_tx, base_sel;
    logic [OFS_W-1:0]  reg_ofs;

    int checks = 0;
    int failures = 0;

    logic              exp_line = 1'b1;
    logic              exp_brx = 1'b0;
    logic [NUM_CH-1:0] exp_crx = '0;

    always #5 clk = ~clk;

    isdn_slot_steer #(.NUM_CH(NUM_CH), .SLOT_W(SLOT_W), .ADDR_W(ADDR_W)) uut (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [NUM_CH-1:0] exp_en_f(logic stb, logic en, logic [SLOT_W-1:0] s);
        logic [NUM_CH-1:0] r = '0;
        for (int k = 0; k < NUM_CH; k++) if (stb && en && s == SLOT_W'(k)) r[k] = 1'b1;
        return r;
    endfunction

    function automatic logic exp_line_f(logic stb, logic en, logic [SLOT_W-1:0] s,
                                        logic bbit, logic [NUM_CH-1:0] tb,
                                        logic [NUM_CH-1:0] tv, logic prev);
        if (!stb) return prev;
        if (en && s < SLOT_W'(NUM_CH)) return tv[s] ? tb[s] : 1'b1;
        return bbit;
    endfunction

    function automatic string line_tag(logic stb, logic en, logic [SLOT_W-1:0] s,
                                       logic [NUM_CH-1:0] tv);
        if (!stb) return "R9";
        if (s >= SLOT_W'(NUM_CH)) return "R8";
        if (!en) return "R3";
        return tv[s] ? "R6" : "R7";
    endfunction

    // Drive at negedge, let one edge pass, compare away from the edge.
    task automatic step(input logic stb, input logic en, input logic [SLOT_W-1:0] s,
                        input logic rx, input logic bbit, input logic [NUM_CH-1:0] tb,
                        input logic [NUM_CH-1:0] tv, input logic [ADDR_W-1:0] a);
        logic [NUM_CH-1:0] e_en;
        logic [3:0]        nib;
        logic [NUM_CH-1:0] e_sel;
        bit_stb = stb; isdn_en = en; slot_idx = s; line_rx = rx;
        buf_tx_bit = bbit; hdlc_tx_bit = tb; hdlc_tx_vld = tv; cpu_addr = a;
        e_en     = exp_en_f(stb, en, s);
        exp_line = exp_line_f(stb, en, s, bbit, tb, tv, exp_line);
        for (int k = 0; k < NUM_CH; k++) if (e_en[k]) exp_crx[k] = rx;
        if (stb) exp_brx = rx;
        nib   = a[ADDR_W-1 -: 4];
        e_sel = '0;
        if (nib >= 4'd1 && nib <= 4'(NUM_CH)) e_sel[nib - 4'd1] = 1'b1;
        @(posedge clk);
        #2;
        check(en ? "R2 ch_en" : "R3 ch_en", 32'(ch_en), 32'(e_en));
        check("R4 ch_rx_bit", 32'(ch_rx_bit), 32'(exp_crx));
        check("R5 buf_rx_stb", 32'(buf_rx_stb), 32'(stb));
        check("R5 buf_rx_bit", 32'(buf_rx_bit), 32'(exp_brx));
        check({line_tag(stb, en, s, tv), " line_tx"}, 32'(line_tx), 32'(exp_line));
        check(e_sel != '0 ? "R10 ch_sel" : "R11 ch_sel", 32'(ch_sel), 32'(e_sel));
        check(e_sel != '0 ? "R10 base_sel" : "R11 base_sel", 32'(base_sel), 32'(e_sel == '0));
        check(e_sel != '0 ? "R10 reg_ofs" : "R11 reg_ofs", 32'(reg_ofs), 32'(a[OFS_W-1:0]));
        @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 ch_en", 32'(ch_en), 32'h0);
        check("R1 line_tx", 32'(line_tx), 32'h1);
        check("R1 base_sel", 32'(base_sel), 32'h1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ch_rx_bit", 32'(ch_rx_bit), 32'h0);
        check("R1 buf_rx_stb", 32'(buf_rx_stb), 32'h0);
        check("R1 ch_sel", 32'(ch_sel), 32'h0);
        check("R1 reg_ofs", 32'(reg_ofs), 32'h0);

        // Directed full-frame sweeps in both modes, with strobe gaps (R9).
        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 32; s++) begin
                step(1'b1, m[0], SLOT_W'(s), s[0], ~s[1], 3'b101, 3'b011, 8'(s << 3));
                step(1'b0, m[0], SLOT_W'(s), ~s[0], s[1], 3'b010, 3'b111, 8'h00);
            end
        end
        // R7: channel without valid bit drives 1 even with zeros elsewhere.
        step(1'b1, 1'b1, 5'd2, 1'b0, 1'b0, 3'b000, 3'b000, 8'h20);
        // R8: slot 3 ignores HDLC inputs in ISDN mode.
        step(1'b1, 1'b1, 5'd3, 1'b0, 1'b0, 3'b111, 3'b111, 8'h40);
        // R10/R11 window edges.
        step(1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 3'b000, 3'b000, 8'h3F);
        step(1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 3'b000, 3'b000, 8'h0F);
        step(1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 3'b000, 3'b000, 8'hF1);

        // Random traffic biased toward the steered slots.
        for (int i = 0; i < 3000; i++) begin
            logic [SLOT_W-1:0] s;
            s = ($urandom % 2 == 0) ? SLOT_W'($urandom % 5) : SLOT_W'($urandom);
            step(1'(($urandom % 3) != 0), 1'(($urandom % 4) != 0), s, 1'($urandom),
                 1'($urandom), 3'($urandom), 3'($urandom), 8'($urandom));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule